// File: doc/BRIEF.md
# Carry-less multiplier with half-select

This block forms the XOR product of two WIDTH-bit operands, each read as a polynomial over GF(2). Bit i of the first operand selects a copy of the second operand shifted left by i places. All the selected copies are combined with exclusive-or, so no carry ever reaches a higher column. The full product has at most 2*WIDTH-1 significant bits and is kept in a 2*WIDTH-bit word. A two-bit selector then returns one WIDTH-bit window of that word.

Operands enter through a valid/ready handshake and the selected window leaves through a second one. The parameter ITERATIVE picks the engine. The iterative engine takes one bit of the first operand per clock. The combinational engine builds the whole product at once and captures it on the accepting edge. A controller with three states sequences the work:

- ST_IDLE waits for operands and is the only state with in_ready high.
- ST_RUN steps the iterative engine once per clock.
- ST_DONE holds the result until the consumer takes it.

The transitions are:

- IDLE to RUN: an accept in iterative mode.
- IDLE to DONE: an accept in combinational mode.
- RUN to DONE: after the WIDTH-th step.
- DONE to IDLE: when out_valid and out_ready are both high.

Top module: `clmul_unit`

## Requirements
- R1: Full product bit k equals the XOR over all i+j=k of op_a[i] AND op_b[j]; selector 2'b00 returns product bits WIDTH-1..0.
- R2: Selector 2'b01 returns product bits 2*WIDTH-1..WIDTH; the top bit of this window is always 0.
- R3: Selector 2'b10 returns product bits 2*WIDTH-2..WIDTH-1.
- R4: Selector 2'b11 returns all zeros, whatever the operands.
- R5: With op_a = 8'b10100010 and op_b = 8'b10010110 zero-extended, selector 2'b00 yields 15'b101100011101100 and selector 2'b01 yields 0.
- R6: Swapping op_a and op_b gives the same result for every selector.
- R7: A zero operand gives zero under every selector. All-ones operands give a product with ones at the even positions only.
- R8: in_ready is high only in ST_IDLE. Operands and selector are accepted on a rising edge where in_valid and in_ready are both high; inputs in other cycles are ignored.
- R9: out_valid rises on the accepting edge in combinational mode, or on the WIDTH-th edge after it in iterative mode.
- R10: While out_valid is high and out_ready is low, out_data is stable, out_valid stays high and in_ready stays low.
- R11: An edge with out_valid and out_ready both high drops out_valid and raises in_ready for the next cycle.
- R12: After reset, out_valid is 0, in_ready is 1 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selector are presented |
| in_ready | output | 1 | Block can accept operands |
| op_a | input | WIDTH | First polynomial operand |
| op_b | input | WIDTH | Second polynomial operand |
| op_sel | input | 2 | Window select: 00 low, 01 high, 10 shifted, 11 zero |
| out_valid | output | 1 | out_data holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | WIDTH | Selected window of the full product |

## Verification
Each selector is tried with the following operand patterns:

- The worked 8-bit pair has two columns where a pair of ones cancels, so an adder with carries would give a different answer.
- Single-bit operands place exactly one product bit. They show whether each window is aligned to the right bit position.
- Zero and all-ones operands separate a correct XOR fold from OR-combining or from dropped partial products.
- Random pairs, run in both operand orders, expose asymmetric errors.

The bench compares every result against a shift-and-XOR reference loop.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'b00,
        SEL_HIGH  = 2'b01,
        SEL_SHIFT = 2'b10,
        SEL_ZERO  = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } state_e;

endpackage

// File: rtl/clmul_comb.sv
module clmul_comb #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] part [WIDTH];

    // one shifted copy of b per bit of a
    for (genvar i = 0; i < WIDTH; i++) begin : g_part
        assign part[i] = a[i] ? ({{WIDTH{1'b0}}, b} << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < WIDTH; i++) begin
            prod = prod ^ part[i];
        end
    end
endmodule

// File: rtl/clmul_iter.sv
module clmul_iter #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] a_sh;
    logic [PW-1:0]    b_sh;
    logic [PW-1:0]    acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_sh <= '0;
            acc  <= '0;
        end else if (load) begin
            a_sh <= a;
            b_sh <= {{WIDTH{1'b0}}, b};
            acc  <= '0;
        end else if (step) begin
            if (a_sh[0]) begin
                acc <= acc ^ b_sh;
            end
            a_sh <= a_sh >> 1;
            b_sh <= b_sh << 1;
        end
    end

    assign prod = acc;
endmodule

// File: rtl/clmul_slice.sv
module clmul_slice
    import clmul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] prod,
    input  sel_e               sel,
    output logic [WIDTH-1:0]   win
);
    always_comb begin
        unique case (sel)
            SEL_LOW:   win = prod[WIDTH-1:0];
            SEL_HIGH:  win = prod[2*WIDTH-1:WIDTH];
            SEL_SHIFT: win = prod[2*WIDTH-2:WIDTH-1];
            SEL_ZERO:  win = '0;
            default:   win = '0;
        endcase
    end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
    import clmul_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       op_sel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    localparam int PW = 2 * WIDTH;
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    sel_e          sel_q;
    logic          accept, step, last_step;
    logic [PW-1:0] prod;

    assign accept    = in_valid && in_ready;
    assign last_step = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ITERATIVE ? ST_RUN : ST_DONE;
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_RUN:  step      = 1'b1;
            ST_DONE: out_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= SEL_LOW;
        end else if (accept) begin
            cnt_q <= '0;
            sel_q <= sel_e'(op_sel);
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    if (ITERATIVE) begin : g_iter
        clmul_iter #(.WIDTH(WIDTH)) u_eng (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (accept),
            .step  (step),
            .a     (op_a),
            .b     (op_b),
            .prod  (prod)
        );
    end else begin : g_comb
        logic [PW-1:0] prod_c, prod_q;
        clmul_comb #(.WIDTH(WIDTH)) u_eng (
            .a    (op_a),
            .b    (op_b),
            .prod (prod_c)
        );
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prod_q <= '0;
            else if (accept) prod_q <= prod_c;
        end
        assign prod = prod_q;
    end

    clmul_slice #(.WIDTH(WIDTH)) u_slice (
        .prod (prod),
        .sel  (sel_q),
        .win  (out_data)
    );
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk #(
    parameter int WIDTH     = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       op_sel,
    input logic             out_valid,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_data
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

    // R4
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && op_sel == 2'b11 && !ITERATIVE |=> out_data == '0);

    if (ITERATIVE && WIDTH > 1) begin : g_lat_iter
        // R9
        iter_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |=> !out_valid && !in_ready);
    end else begin : g_lat_comb
        // R9
        comb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |=> out_valid);
    end
endmodule

bind clmul_unit clmul_unit_chk #(.WIDTH(WIDTH), .ITERATIVE(ITERATIVE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/clmul_unit_bench.sv
`timescale 1ns/1ps
module clmul_unit_bench;
    localparam int W = 32;
    localparam bit ITER = 1'b1;
    localparam int NV = 8;

    localparam logic [W-1:0] TA [NV] = '{32'h000000A2, 32'h00000001, 32'h80000000, 32'h80000000,
                                         32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678};
    localparam logic [W-1:0] TB [NV] = '{32'h00000096, 32'h80000000, 32'h80000000, 32'h80000000,
                                         32'hDEADBEEF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h9ABCDEF0};
    localparam logic [1:0]   TS [NV] = '{2'b00, 2'b10, 2'b01, 2'b10,
                                         2'b01, 2'b00, 2'b10, 2'b11};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [1:0] op_sel = 2'b00;
    logic in_ready, out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    always #10 clk = ~clk;

    clmul_unit #(.WIDTH(W), .ITERATIVE(ITER)) u_clmul_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p = '0;
        for (int i = 0; i < W; i++)
            if (a[i]) p = p ^ ({{W{1'b0}}, b} << i);
        return p;
    endfunction

    function automatic logic [W-1:0] ref_win(input logic [2*W-1:0] p, input logic [1:0] s);
        case (s)
            2'b00:   return p[W-1:0];
            2'b01:   return p[2*W-1:W];
            2'b10:   return p[2*W-2:W-1];
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one operation; hold result for `hold` cycles before taking it
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s,
                          input int hold, output logic [W-1:0] res);
        int lat;
        logic [W-1:0] first;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_sel = s;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; op_a = ~a; op_b = ~b; op_sel = ~s;
        lat = 0;
        while (!out_valid && lat < 4 * W) begin
            @(negedge clk);
            lat++;
        end
        check("R9 latency", W'(lat), ITER ? W'(W) : W'(0));
        first = out_data;
        for (int h = 0; h < hold; h++) begin
            in_valid = 1'b1;   // R8: must be ignored while busy
            @(negedge clk);
            check("R10 data stable", out_data, first);
            check("R10 valid held / ready low", {30'd0, out_valid, in_ready}, 32'd2);
        end
        in_valid = 1'b0;
        res = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R11 released", {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] r, r2;
        repeat (3) @(negedge clk);
        // R12
        check("R12 reset state", {out_data[29:0], out_valid, in_ready},
              {30'd0, 1'b0, 1'b1});
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R7
        for (int v = 0; v < NV; v++) begin
            run_op(TA[v], TB[v], TS[v], v % 3, r);
            check("R1/R2/R3/R4/R7 table", r, ref_win(ref_prod(TA[v], TB[v]), TS[v]));
        end

        // R5 worked example
        run_op(32'hA2, 32'h96, 2'b00, 0, r);
        check("R5 example low", r, 32'h000058EC);
        run_op(32'hA2, 32'h96, 2'b01, 0, r);
        check("R5 example high", r, 32'h0);

        // R7 all ones: even positions only
        run_op('1, '1, 2'b00, 0, r);
        check("R7 all-ones low", r, 32'h55555555);
        run_op('1, '1, 2'b01, 0, r);
        check("R7 all-ones high", r, 32'h55555555);
        run_op('1, 32'h0, 2'b10, 0, r);
        check("R7 zero operand", r, 32'h0);

        // R4 reserved selector zero
        run_op('1, '1, 2'b11, 1, r);
        check("R4 zero select", r, 32'h0);

        // R2 top bit of high window is zero
        run_op('1, '1, 2'b01, 0, r);
        check("R2 high top bit", {31'd0, r[W-1]}, 32'd0);

        // random patterns, all selectors, both orders: R1 R2 R3 R6
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] a = $urandom();
            logic [W-1:0] b = $urandom();
            logic [1:0] s = 2'(k % 3);
            run_op(a, b, s, k % 2, r);
            check("R1/R2/R3 random", r, ref_win(ref_prod(a, b), s));
            run_op(b, a, s, 0, r2);
            check("R6 commutative", r2, r);
        end

        if (!timed_out) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule